// File: doc/BRIEF.md
# MDIO Command Master

This block runs clause-22 management frames towards external PHYs. It is driven by one 32-bit command/status word. Software writes a word with the busy bit set. The word also carries the operation (read or write), a two-bit channel number, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then serialises one frame on the chosen channel out of four. Each channel has its own MDC clock output and its own tri-state MDIO data line, split into output value, output enable and input.

Software polls the same word. When the frame ends, the busy bit reads 0. After a read, the low 16 bits hold the value the PHY returned, and every other field is kept. MDC runs at the system clock divided by a fixed parameter. The frame occupies 64 MDC periods. The data line is updated only after an MDC falling edge and is sampled on an MDC rising edge.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0x00000000, every `mdc` bit is 0 and every `mdio_oe` bit is 0.
- R2: Writing a word with bit 31 = 1 while idle starts one frame on the channel named by bits 29:28 (0 to 3 maps to pin index 0 to 3). Bit 31 reads 1 for exactly 128·HALF_DIV clock cycles after the accepting edge, and then reads 0.
- R3: Writing a word with bit 31 = 0 while idle stores the word unchanged and starts no frame, so all MDC and MDIO enable outputs stay 0.
- R4: Any write presented while bit 31 reads 1 is ignored. The command word and the running frame are unaffected.
- R5: During a frame, only the selected channel's `mdc` toggles. Each period is HALF_DIV cycles low followed by HALF_DIV cycles high, starting low. All other `mdc` bits stay 0.
- R6: The 64 frame bits are sent MSB first, one per MDC period, in this order: 32 ones, start 01, opcode, PHY address (bits 25:21), register address (bits 20:16), turnaround, data (bits 15:0). The MDIO value changes only with an MDC falling edge.
- R7: Bit 27 selects the operation: 0 = write (opcode 01, turnaround 10, data driven), 1 = read (opcode 10). On a read, `mdio_oe` goes low from the first turnaround bit (frame bit 46) to the end of the frame.
- R8: On a read, the value on the selected `mdio_i` is taken at the MDC rising edge of each of frame bits 48 to 63. Bit 48 becomes data bit 15. At completion these 16 bits replace bits 15:0 and bit 31 clears; bits 30:16 are unchanged.
- R9: At the end of a write frame, only bit 31 changes (to 0). The data field keeps the written value.
- R10: The `mdio_oe` bit of every unselected channel stays 0 at all times, and the `mdio_i` of unselected channels has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word to write |
| rd_data | output | 32 | Current command/status word |
| mdc | output | 4 | Management clock per channel |
| mdio_o | output | 4 | MDIO output value per channel |
| mdio_oe | output | 4 | MDIO output enable per channel (1 = drive) |
| mdio_i | input | 4 | MDIO input per channel |

## Verification
Frames are issued as writes and reads on all four channels. The addresses include all-ones and all-zeros, and the data includes 0x0000, 0xFFFF, 0x0001 and mixed patterns. These values show whether opcode bits, turnaround and bit order are placed correctly, and whether read data is assembled MSB first rather than reversed or shifted by one.

Unselected channels have their inputs held high, so any read from the wrong pin shows up. A write is issued in the middle of a frame to show that busy-time writes are dropped. A word with the busy bit clear shows that storing alone never starts a frame.

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [3:0]  mdc,
  output logic [3:0]  mdio_o,
  output logic [3:0]  mdio_oe,
  input  logic [3:0]  mdio_i
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [31:0]   cmd_q;
  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic [5:0]    bit_q;
  logic [63:0]   sh_q;
  logic [15:0]   rx_q;

  wire       busy     = cmd_q[31];
  wire       is_rd    = cmd_q[27];
  wire [1:0] ch       = cmd_q[29:28];
  wire       half_end = (cnt_q == CW'(HALF_DIV - 1));
  wire       released = is_rd && (bit_q >= 6'd46);
  wire [3:0] sel      = busy ? (4'b0001 << ch) : 4'b0000;

  assign rd_data = cmd_q;
  assign mdc     = phase_q ? sel : 4'b0000;
  assign mdio_oe = released ? 4'b0000 : sel;
  assign mdio_o  = mdio_oe & {4{sh_q[63]}};

  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01,
                       (wr_data[27] ? 2'b10 : 2'b01),
                       wr_data[25:21], wr_data[20:16],
                       2'b10, wr_data[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
    end else if (busy) begin
      if (!half_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
          if (is_rd && bit_q >= 6'd48) rx_q <= {rx_q[14:0], mdio_i[ch]};
        end else begin
          phase_q <= 1'b0;
          sh_q    <= sh_q << 1;
          if (bit_q == 6'd63) begin
            bit_q     <= '0;
            cmd_q[31] <= 1'b0;
            if (is_rd) cmd_q[15:0] <= rx_q;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end else if (wr_en) begin
      cmd_q <= wr_data;
      if (wr_data[31]) begin
        sh_q    <= frame;
        bit_q   <= '0;
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end
    end
  end

  // R5
  mdc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdc));

  // R10
  oe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdio_oe));

  // R6
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mdc) |-> $stable(mdio_o));

  // R4
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && wr_en) |=> (rd_data[30:16] == $past(rd_data[30:16])));

  // R9
  write_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_data[31]) && !rd_data[27]) |-> (rd_data[15:0] == $past(rd_data[15:0])));
endmodule

// File: tb/mdio_cmd_master_tb.sv
module mdio_cmd_master_tb_top;
  localparam int HALF = 2;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  mdc, mdio_o, mdio_oe;
  logic [3:0]  mdio_i = 4'hF;

  always #2 clk = ~clk;

  mdio_cmd_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;
  bit mbusy = 0;
  logic [31:0] mword = '0;
  int t = 0;
  logic fbits [0:63];
  logic [15:0] resp = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] mkcmd(input bit go, input bit rd, input int chn,
                                        input int phy, input int rg, input int dat);
    logic [31:0] w;
    w = '0;
    w[31] = go;
    w[29:28] = chn[1:0];
    w[27] = rd;
    w[25:21] = phy[4:0];
    w[20:16] = rg[4:0];
    w[15:0] = dat[15:0];
    return w;
  endfunction

  task automatic build_frame(input logic [31:0] w);
    for (int i = 0; i < 32; i++) fbits[i] = 1'b1;
    fbits[32] = 1'b0; fbits[33] = 1'b1;
    fbits[34] = w[27]; fbits[35] = ~w[27];
    for (int i = 0; i < 5; i++) begin
      fbits[36 + i] = w[25 - i];
      fbits[41 + i] = w[20 - i];
    end
    fbits[46] = 1'b1; fbits[47] = 1'b0;
    for (int i = 0; i < 16; i++) fbits[48 + i] = w[15 - i];
  endtask

  // reference model, state after each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mword = '0; t = 0;
    end else if (mbusy) begin
      if (t == FRAME_CYC - 1) begin
        mbusy = 0;
        mword[31] = 1'b0;
        if (mword[27]) mword[15:0] = resp;
      end else begin
        t++;
      end
    end else if (wr_en) begin
      mword = wr_data;
      if (wr_data[31]) begin
        mbusy = 1; t = 0;
        build_frame(wr_data);
      end
    end
    started = 1;
  end

  // per-cycle comparison and PHY response
  always @(negedge clk) begin
    int b;
    int chn;
    logic [3:0] emdc, eoe;
    b = t / (2 * HALF);
    chn = int'(mword[29:28]);
    emdc = 4'h0; eoe = 4'h0;
    if (mbusy) begin
      if (((t / HALF) % 2) == 1) emdc = 4'b0001 << chn;
      if (!(mword[27] && b >= 46)) eoe = 4'b0001 << chn;
    end
    if (started) begin
      chk(rd_data === mword, "R4 command word", rd_data, mword);
      chk(mdc === emdc, "R5 mdc", {28'h0, mdc}, {28'h0, emdc});
      chk(mdio_oe === eoe, mword[27] ? "R7 read release" : "R10 enable",
          {28'h0, mdio_oe}, {28'h0, eoe});
      if (eoe != 4'h0)
        chk(mdio_o[chn] === fbits[b], "R6 frame bit", {31'h0, mdio_o[chn]}, {31'h0, fbits[b]});
    end
    mdio_i = 4'hF;
    if (mbusy && mword[27] && b >= 48) mdio_i[chn] = resp[63 - b];
  end

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (rd_data[31] && n < 10000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    wrap_up();
  end

  initial begin
    int n;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R1
    chk(rd_data === 32'h0, "R1 reset word", rd_data, 32'h0);
    chk({mdc, mdio_oe} === 8'h0, "R1 reset pins", {24'h0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // write on ch0, with a write attempt mid-frame (R4)
    w = mkcmd(1, 0, 0, 5'h15, 5'h0A, 16'hA5C3);
    issue(w);
    repeat (60) @(negedge clk);
    issue(mkcmd(1, 1, 3, 5'h02, 5'h03, 16'h1111));
    chk(rd_data === w, "R4 mid-frame write dropped", rd_data, w);
    wait_idle(n);
    w[31] = 1'b0;
    chk(rd_data === w, "R9 write completion", rd_data, w);

    // read on ch2
    resp = 16'h8E71;
    w = mkcmd(1, 1, 2, 5'h01, 5'h1F, 16'h0000);
    issue(w);
    wait_idle(n);
    chk(n == FRAME_CYC, "R2 busy duration", n, FRAME_CYC);
    chk(rd_data === {1'b0, w[30:16], 16'h8E71}, "R8 read data",
        rd_data, {1'b0, w[30:16], 16'h8E71});

    // write on ch3, zero data, extreme addresses
    w = mkcmd(1, 0, 3, 5'h1F, 5'h00, 16'h0000);
    issue(w);
    wait_idle(n);
    chk(n == FRAME_CYC, "R2 busy duration ch3", n, FRAME_CYC);
    w[31] = 1'b0;
    chk(rd_data === w, "R9 write completion ch3", rd_data, w);

    // reads on ch1 and ch0
    resp = 16'hFFFF;
    w = mkcmd(1, 1, 1, 5'h00, 5'h15, 16'h1234);
    issue(w);
    wait_idle(n);
    chk(rd_data === {1'b0, w[30:16], 16'hFFFF}, "R8 read all ones",
        rd_data, {1'b0, w[30:16], 16'hFFFF});
    resp = 16'h0001;
    w = mkcmd(1, 1, 0, 5'h0C, 5'h11, 16'hFFFF);
    issue(w);
    wait_idle(n);
    chk(rd_data === {1'b0, w[30:16], 16'h0001}, "R8 read lsb only",
        rd_data, {1'b0, w[30:16], 16'h0001});

    // store without start
    w = mkcmd(0, 1, 2, 5'h0A, 5'h05, 16'h1234);
    issue(w);
    repeat (20) @(negedge clk);
    chk(rd_data === w, "R3 stored word", rd_data, w);
    chk({mdc, mdio_oe} === 8'h0, "R3 no frame", {24'h0, mdc, mdio_oe}, 32'h0);

    // a frame started after the stored word
    w = mkcmd(1, 0, 2, 5'h0B, 5'h06, 16'h5A5A);
    issue(w);
    wait_idle(n);
    chk(n == FRAME_CYC, "R2 busy after store", n, FRAME_CYC);
    repeat (4) @(negedge clk);
    wrap_up();
  end
endmodule